// File: doc/BRIEF.md
# Interval-Splitting Broadcast Routing Node

This block is a single two-output switch element for one stage of a self-routing broadcast banyan network. Each arriving cell carries a header that names a contiguous range of output addresses as two N-bit values, a lower bound and an upper bound. Bit 1 is the most significant bit. A node placed at stage k looks only at bit k of the two bounds.

When the two bits match, the node forwards the cell unchanged on the link they name. When the lower bound has 0 and the upper bound has 1, the node copies the cell onto both links. It cuts the range at bit k, so that each copy carries only the half of the range that lies behind its own link.

All outputs are registered and appear one cycle after the input. A header that cannot reach stage k in a correctly built network is dropped and raises a sticky error flag. Two kinds of header fall in this class: one whose bits above bit k differ between the bounds, and one with lower bit k = 1 and upper bit k = 0. The stage index, the address width and the payload width are parameters.

Top module: `isbr_node`

## Requirements
- R1: After reset, both link valid outputs and the error flag are 0. Reset is synchronous and active low.
- R2: A valid cell whose lower and upper bit k are both 0 appears on link 0 only, with both bounds unchanged. It appears on the clock edge after the one that samples the input. Bit k of an ADDR_W-wide vector is vector index ADDR_W-STAGE.
- R3: A valid cell whose lower and upper bit k are both 1 appears on link 1 only, with both bounds unchanged, one cycle later.
- R4: A valid cell with lower bit k = 0 and upper bit k = 1 appears on both links in the same cycle, one cycle later.
- R5: In a split, the link-0 copy keeps the lower bound. Its upper bound keeps the bits above bit k, has bit k cleared, and has every bit below bit k set.
- R6: In a split, the link-1 copy keeps the upper bound. Its lower bound keeps the bits above bit k, has bit k set, and has every bit below bit k cleared.
- R7: Every link that carries a cell or a copy of it presents the input payload unchanged.
- R8: A valid cell with lower bit k = 1 and upper bit k = 0 produces no output on either link, and the error flag is 1 one cycle later.
- R9: A valid cell whose bits above bit k differ between the two bounds produces no output on either link, and the error flag is 1 one cycle later.
- R10: Once set, the error flag stays 1 until reset, and later valid cells are still routed normally.
- R11: A cycle with the input valid low produces no output valid on either link in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| in_vld_i | input | 1 | Input cell present |
| in_lo_i | input | ADDR_W | Lower bound of the address range |
| in_hi_i | input | ADDR_W | Upper bound of the address range |
| in_pay_i | input | PAY_W | Cell payload |
| l0_vld_o | output | 1 | Link 0 carries a cell |
| l0_lo_o | output | ADDR_W | Link 0 lower bound |
| l0_hi_o | output | ADDR_W | Link 0 upper bound |
| l0_pay_o | output | PAY_W | Link 0 payload |
| l1_vld_o | output | 1 | Link 1 carries a cell |
| l1_lo_o | output | ADDR_W | Link 1 lower bound |
| l1_hi_o | output | ADDR_W | Link 1 upper bound |
| l1_pay_o | output | PAY_W | Link 1 payload |
| err_o | output | 1 | Sticky malformed-header flag |

## Verification
Every result of this node is due exactly one rising edge after the edge that samples the input. This holds for both link valids, the rewritten bounds, the payloads and the error flag. The driver presents each cell on a falling edge and queues its expected result, computed from the requirements by shifting the bounds arithmetically. The monitor pops one queued item on each following rising edge and compares 5 ns after that edge, so every check falls exactly one register stage after its stimulus and never at an edge. The reset values are checked while reset is held.

// File: rtl/isbr_pkg.sv
package isbr_pkg;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_LOW  = 2'd1,
      ROUTE_HIGH = 2'd2,
      ROUTE_BOTH = 2'd3
   } route_e;

   function automatic logic link_taken(route_e r, int unsigned link);
      if (r == ROUTE_BOTH) return 1'b1;
      if (link == 0)       return r == ROUTE_LOW;
      return r == ROUTE_HIGH;
   endfunction

endpackage

// File: rtl/isbr_decode.sv
module isbr_decode
   import isbr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int STAGE  = 2
) (
   input  logic              in_vld_i,
   input  logic [ADDR_W-1:0] lo_i,
   input  logic [ADDR_W-1:0] hi_i,
   output route_e            route_o,
   output logic              fault_o
);
   localparam int POS = ADDR_W - STAGE;

   logic prefix_ok;

   generate
      if (STAGE == 1) begin : g_no_prefix
         assign prefix_ok = 1'b1;
      end else begin : g_prefix
         localparam logic [ADDR_W-1:0] KBIT = ADDR_W'(1) << POS;
         localparam logic [ADDR_W-1:0] UP_MASK = ~((KBIT - ADDR_W'(1)) | KBIT);
         assign prefix_ok = ((lo_i ^ hi_i) & UP_MASK) == '0;
      end
   endgenerate

   always_comb begin
      route_o = ROUTE_NONE;
      fault_o = 1'b0;
      if (in_vld_i) begin
         if (!prefix_ok) begin
            fault_o = 1'b1;
         end else begin
            unique case ({lo_i[POS], hi_i[POS]})
               2'b00:   route_o = ROUTE_LOW;
               2'b11:   route_o = ROUTE_HIGH;
               2'b01:   route_o = ROUTE_BOTH;
               default: fault_o = 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/isbr_split.sv
module isbr_split #(
   parameter int ADDR_W = 4,
   parameter int STAGE  = 2,
   parameter int LINK   = 0
) (
   input  logic              split_i,
   input  logic [ADDR_W-1:0] lo_i,
   input  logic [ADDR_W-1:0] hi_i,
   output logic [ADDR_W-1:0] lo_o,
   output logic [ADDR_W-1:0] hi_o
);
   localparam int POS = ADDR_W - STAGE;
   localparam logic [ADDR_W-1:0] KBIT     = ADDR_W'(1) << POS;
   localparam logic [ADDR_W-1:0] LOW_MASK = KBIT - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] UP_MASK  = ~(LOW_MASK | KBIT);

   generate
      if (LINK == 0) begin : g_low_half
         assign lo_o = lo_i;
         assign hi_o = split_i ? ((hi_i & UP_MASK) | LOW_MASK) : hi_i;
      end else begin : g_high_half
         assign hi_o = hi_i;
         assign lo_o = split_i ? ((lo_i & UP_MASK) | KBIT) : lo_i;
      end
   endgenerate
endmodule

// File: rtl/isbr_out_reg.sv
module isbr_out_reg #(
   parameter int ADDR_W = 4,
   parameter int PAY_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              send_i,
   input  logic [ADDR_W-1:0] lo_i,
   input  logic [ADDR_W-1:0] hi_i,
   input  logic [PAY_W-1:0]  pay_i,
   output logic              vld_o,
   output logic [ADDR_W-1:0] lo_o,
   output logic [ADDR_W-1:0] hi_o,
   output logic [PAY_W-1:0]  pay_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vld_o <= 1'b0;
         lo_o  <= '0;
         hi_o  <= '0;
         pay_o <= '0;
      end else begin
         vld_o <= send_i;
         if (send_i) begin
            lo_o  <= lo_i;
            hi_o  <= hi_i;
            pay_o <= pay_i;
         end
      end
   end
endmodule

// File: rtl/isbr_node.sv
module isbr_node
   import isbr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int STAGE  = 2,
   parameter int PAY_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_vld_i,
   input  logic [ADDR_W-1:0] in_lo_i,
   input  logic [ADDR_W-1:0] in_hi_i,
   input  logic [PAY_W-1:0]  in_pay_i,
   output logic              l0_vld_o,
   output logic [ADDR_W-1:0] l0_lo_o,
   output logic [ADDR_W-1:0] l0_hi_o,
   output logic [PAY_W-1:0]  l0_pay_o,
   output logic              l1_vld_o,
   output logic [ADDR_W-1:0] l1_lo_o,
   output logic [ADDR_W-1:0] l1_hi_o,
   output logic [PAY_W-1:0]  l1_pay_o,
   output logic              err_o
);
   localparam int NLINK = 2;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("isbr_node: ADDR_W must be at least 1");
      end
      if (STAGE < 1 || STAGE > ADDR_W) begin : g_bad_stage
         $error("isbr_node: STAGE must lie in 1..ADDR_W");
      end
      if (PAY_W < 1) begin : g_bad_pay
         $error("isbr_node: PAY_W must be at least 1");
      end
   endgenerate

   route_e route;
   logic   fault;
   logic   err_q;

   logic              vld_q [NLINK];
   logic [ADDR_W-1:0] lo_q  [NLINK];
   logic [ADDR_W-1:0] hi_q  [NLINK];
   logic [PAY_W-1:0]  pay_q [NLINK];

   isbr_decode #(.ADDR_W(ADDR_W), .STAGE(STAGE)) dec_i (
      .in_vld_i (in_vld_i),
      .lo_i     (in_lo_i),
      .hi_i     (in_hi_i),
      .route_o  (route),
      .fault_o  (fault)
   );

   generate
      for (genvar j = 0; j < NLINK; j++) begin : g_link
         logic              send;
         logic [ADDR_W-1:0] lo_n;
         logic [ADDR_W-1:0] hi_n;

         assign send = link_taken(route, j);

         isbr_split #(.ADDR_W(ADDR_W), .STAGE(STAGE), .LINK(j)) split_i (
            .split_i (route == ROUTE_BOTH),
            .lo_i    (in_lo_i),
            .hi_i    (in_hi_i),
            .lo_o    (lo_n),
            .hi_o    (hi_n)
         );

         isbr_out_reg #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) oreg_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .send_i (send),
            .lo_i   (lo_n),
            .hi_i   (hi_n),
            .pay_i  (in_pay_i),
            .vld_o  (vld_q[j]),
            .lo_o   (lo_q[j]),
            .hi_o   (hi_q[j]),
            .pay_o  (pay_q[j])
         );
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) err_q <= 1'b0;
      else         err_q <= err_q | fault;
   end

   assign l0_vld_o = vld_q[0];
   assign l0_lo_o  = lo_q[0];
   assign l0_hi_o  = hi_q[0];
   assign l0_pay_o = pay_q[0];
   assign l1_vld_o = vld_q[1];
   assign l1_lo_o  = lo_q[1];
   assign l1_hi_o  = hi_q[1];
   assign l1_pay_o = pay_q[1];
   assign err_o    = err_q;
endmodule

// File: rtl/isbr_node_chk.sv
module isbr_node_chk #(
   parameter int ADDR_W = 4,
   parameter int STAGE  = 2,
   parameter int PAY_W  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              in_vld_i,
   input logic [ADDR_W-1:0] in_lo_i,
   input logic [ADDR_W-1:0] in_hi_i,
   input logic [PAY_W-1:0]  in_pay_i,
   input logic              l0_vld_o,
   input logic [ADDR_W-1:0] l0_lo_o,
   input logic [ADDR_W-1:0] l0_hi_o,
   input logic [PAY_W-1:0]  l0_pay_o,
   input logic              l1_vld_o,
   input logic [ADDR_W-1:0] l1_lo_o,
   input logic [ADDR_W-1:0] l1_hi_o,
   input logic [PAY_W-1:0]  l1_pay_o,
   input logic              err_o
);
   localparam int POS = ADDR_W - STAGE;

   // R11: no output without an input one cycle earlier
   p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_vld_i |=> !l0_vld_o && !l1_vld_o);

   // R4: a 0/1 pair on bit k yields both copies together
   p_split_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_vld_i && (in_lo_i[ADDR_W-1:POS] == {in_hi_i[ADDR_W-1:POS+1], 1'b0})
               && in_hi_i[POS]
      |=> l0_vld_o && l1_vld_o);

   // R5: whatever leaves on link 0 has bit k of its upper bound clear
   p_low_shape_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l0_vld_o |-> !l0_hi_o[POS] && !l0_lo_o[POS]);

   // R6: whatever leaves on link 1 has bit k of its lower bound set
   p_high_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l1_vld_o |-> l1_lo_o[POS] && l1_hi_o[POS]);

   // R7: payload on link 0 is the payload presented one cycle earlier
   p_pay_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l0_vld_o |-> l0_pay_o == $past(in_pay_i));

   // R7: both copies of a split carry the same payload
   p_pay_twin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l0_vld_o && l1_vld_o |-> l0_pay_o == l1_pay_o);

   // R8: an inverted bit-k pair is dropped and flagged
   p_bad_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_vld_i && in_lo_i[POS] && !in_hi_i[POS]
      |=> !l0_vld_o && !l1_vld_o && err_o);

   // R10: the error flag never falls outside reset
   p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);
endmodule

bind isbr_node isbr_node_chk #(.ADDR_W(ADDR_W), .STAGE(STAGE), .PAY_W(PAY_W)) chk_i (.*);

// File: tb/isbr_node_tb_top.sv
module isbr_node_tb_top;
   localparam int AW = 4;
   localparam int ST = 2;
   localparam int PW = 8;
   localparam int B  = AW - ST;

   typedef struct packed {
      logic          v0;
      logic          v1;
      logic [AW-1:0] lo0;
      logic [AW-1:0] hi0;
      logic [AW-1:0] lo1;
      logic [AW-1:0] hi1;
      logic [PW-1:0] pay;
      logic          err;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [AW-1:0] in_lo = '0;
   logic [AW-1:0] in_hi = '0;
   logic [PW-1:0] in_pay = '0;
   logic          l0_vld, l1_vld, err;
   logic [AW-1:0] l0_lo, l0_hi, l1_lo, l1_hi;
   logic [PW-1:0] l0_pay, l1_pay;

   int    checks = 0;
   int    failures = 0;
   logic  done = 1'b0;
   logic  err_model = 1'b0;
   exp_t  exp_q[$];
   string req_q[$];

   always #10 clk = ~clk;

   isbr_node #(.ADDR_W(AW), .STAGE(ST), .PAY_W(PW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_lo_i(in_lo),
      .in_hi_i(in_hi), .in_pay_i(in_pay), .l0_vld_o(l0_vld), .l0_lo_o(l0_lo),
      .l0_hi_o(l0_hi), .l0_pay_o(l0_pay), .l1_vld_o(l1_vld), .l1_lo_o(l1_lo),
      .l1_hi_o(l1_hi), .l1_pay_o(l1_pay), .err_o(err)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic send(string req, logic v, logic [AW-1:0] lo, logic [AW-1:0] hi,
                       logic [PW-1:0] pay);
      exp_t e;
      int upl, uph;
      logic bl, bh;
      @(negedge clk);
      in_vld = v; in_lo = lo; in_hi = hi; in_pay = pay;
      upl = int'(lo) >> (B + 1);
      uph = int'(hi) >> (B + 1);
      bl  = lo[B];
      bh  = hi[B];
      e = '0;
      e.pay = pay;
      e.lo0 = lo; e.hi0 = hi; e.lo1 = lo; e.hi1 = hi;
      if (v) begin
         if (upl != uph || (bl && !bh)) begin
            err_model = 1'b1;
         end else if (!bl && !bh) begin
            e.v0 = 1'b1;
         end else if (bl && bh) begin
            e.v1 = 1'b1;
         end else begin
            e.v0 = 1'b1;
            e.v1 = 1'b1;
            e.hi0 = AW'((uph << (B + 1)) + (1 << B) - 1);
            e.lo1 = AW'((upl << (B + 1)) + (1 << B));
         end
      end
      e.err = err_model;
      exp_q.push_back(e);
      req_q.push_back(req);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) send("R11", 1'b0, AW'(i), AW'(i + 3), PW'(i));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_vld = 1'b0;
      err_model = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", "l0_vld in reset", 32'(l0_vld), 0);
      check("R1", "l1_vld in reset", 32'(l1_vld), 0);
      check("R1", "err in reset", 32'(err), 0);
      rst_n = 1'b1;
   endtask

   // monitor: one queued item per rising edge, compared 5 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            exp_t  e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(r, "l0_vld", 32'(l0_vld), 32'(e.v0));
            check(r, "l1_vld", 32'(l1_vld), 32'(e.v1));
            check(r, "err", 32'(err), 32'(e.err));
            if (e.v0 && l0_vld) begin
               check(r, "l0_lo", 32'(l0_lo), 32'(e.lo0));
               check(r, "l0_hi", 32'(l0_hi), 32'(e.hi0));
               check(r, "l0_pay", 32'(l0_pay), 32'(e.pay));
            end
            if (e.v1 && l1_vld) begin
               check(r, "l1_lo", 32'(l1_lo), 32'(e.lo1));
               check(r, "l1_hi", 32'(l1_hi), 32'(e.hi1));
               check(r, "l1_pay", 32'(l1_pay), 32'(e.pay));
            end
         end
      end
   end

   initial begin
      do_reset();
      idle(2);
      send("R2", 1'b1, 4'b0000, 4'b0011, 8'h11);
      send("R2", 1'b1, 4'b1000, 4'b1011, 8'h22);
      send("R3", 1'b1, 4'b0100, 4'b0111, 8'h33);
      send("R3", 1'b1, 4'b1101, 4'b1110, 8'h44);
      send("R4 R5 R6 R7", 1'b1, 4'b0001, 4'b0110, 8'hA5);
      send("R4 R5 R6 R7", 1'b1, 4'b1000, 4'b1111, 8'h5A);
      send("R5 R6", 1'b1, 4'b0011, 4'b0100, 8'hC3);
      idle(1);
      send("R8", 1'b1, 4'b0100, 4'b0011, 8'h77);
      send("R10", 1'b1, 4'b0000, 4'b0001, 8'h88);
      send("R10", 1'b1, 4'b1010, 4'b1110, 8'h99);
      idle(2);
      do_reset();
      idle(1);
      send("R9", 1'b1, 4'b0000, 4'b1111, 8'h12);
      send("R9", 1'b1, 4'b1100, 4'b0111, 8'h34);
      send("R10", 1'b1, 4'b0110, 4'b0111, 8'h56);
      idle(3);
      wait (exp_q.size() == 0);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule